// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block divides a clock into the oversampling strobe used by a serial receiver and transmitter. A 16-bit time constant, supplied as a high byte and a low byte, sets the division. Each source event moves a down-counter toward zero. At terminal count the counter reloads and a square-wave output changes level, so one full output period lasts 2·(time constant + 2) source events. A one-cycle `baud_tick` marks the end of each full period. A second strobe, `bit_tick`, fires on every sixteenth `baud_tick` and gives the bit rate.

The source events come from one of two places. In primary mode every system clock cycle is a source event. In alternate mode only the cycles in which `alt_ce` is high count. A host picks the time constant as clock / (2·16·baud) − 2. For example, a 4.9152 MHz source with time constant 2 gives 38400 baud. A divisor below 2 has no encoding and is the host's concern. A new time constant is taken at the next reload, or when the generator is switched on. It never cuts into a count in progress.

Top module: `baud_gen`

## Requirements
- R1: The time constant T is {tc_hi, tc_lo}. With primary source (src_main=1), consecutive baud_tick pulses are exactly 2·(T+2) clock cycles apart.
- R2: The smallest time constant, T=0, gives a baud_tick period of 4 cycles.
- R3: T=2 gives a baud_tick period of 8 cycles and a bit_tick period of 128 cycles. This is the divide ratio that turns 4.9152 MHz into 38400 baud.
- R4: baud_tick is high for exactly one clock cycle per period.
- R5: bit_tick is high only together with baud_tick, on every 16th baud_tick. Its period is therefore 32·(T+2) source events.
- R6: Enabling restarts the generator. Call the clock edge that first samples gen_en high after it was low the start edge. The first baud_tick is visible 2·(T+2) cycles after the start edge, and the first bit_tick is visible 32·(T+2) cycles after it.
- R7: While gen_en is low, no baud_tick or bit_tick is produced and baud_clk holds its level.
- R8: With the alternate source (src_main=0), the counter advances only on cycles with alt_ce high. With alt_ce held low, no tick is produced. With alt_ce high one cycle in N, the period is N·2·(T+2) cycles.
- R9: A time constant written during a count takes effect at the next reload. The half-period already under way keeps its old length.
- R10: After synchronous reset, baud_tick, bit_tick and baud_clk are all 0.
- R11: With the primary source selected, alt_ce has no effect on the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the primary source |
| rst | input | 1 | Synchronous active-high reset |
| tc_lo | input | 8 | Time constant, low byte |
| tc_hi | input | 8 | Time constant, high byte |
| gen_en | input | 1 | Generator enable |
| src_main | input | 1 | 1 selects the primary clock, 0 selects the alt_ce strobe |
| alt_ce | input | 1 | Alternate source clock-enable |
| baud_clk | output | 1 | Square wave that changes level at each terminal count |
| baud_tick | output | 1 | One-cycle strobe at the end of each full output period |
| bit_tick | output | 1 | One-cycle strobe on every 16th baud_tick |

## Verification
Each tick is a register written on the edge that sees the terminal count, so it appears in the cycle after that edge. The first baud_tick after an enable therefore sits 2·(T+2) edges after the start edge, and bit_tick follows the same rule at 32·(T+2). The bench keeps a count of clock edges and drives and samples only on falling edges. It converts every pulse into an edge stamp and compares the differences between stamps with these formulas. Before measuring a steady period it discards the first tick. A time constant changed mid-count is applied on the falling edge right after a tick. This gives exactly one old half-period followed by one new half-period in the next interval.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    localparam int BG_BYTE_W = 8;
    localparam int BG_TC_W   = 2 * BG_BYTE_W;
    localparam int BG_CNT_W  = BG_TC_W + 1;

    typedef enum logic {
        SRC_ALT  = 1'b0,
        SRC_MAIN = 1'b1
    } bg_src_e;

    typedef struct packed {
        logic [BG_CNT_W-1:0] count;
        logic                level;
    } bg_half_t;

    // A half period spans T+2 source events: load T+1, act when zero is seen.
    function automatic logic [BG_CNT_W-1:0] bg_reload(input logic [BG_TC_W-1:0] tc);
        return {1'b0, tc} + {{(BG_CNT_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/baud_gen_step.sv
module baud_gen_step
    import baud_gen_pkg::*;
(
    input  logic    gen_en,
    input  logic    start,
    input  bg_src_e src,
    input  logic    alt_ce,
    output logic    step
);

    logic event_raw;

    always_comb begin
        unique case (src)
            SRC_MAIN: event_raw = 1'b1;
            default:  event_raw = alt_ce;
        endcase
        step = gen_en && !start && event_raw;
    end

endmodule

// File: rtl/baud_gen_half.sv
module baud_gen_half
    import baud_gen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               step,
    input  logic [BG_TC_W-1:0] tc,
    output logic               level,
    output logic               full_tick
);

    bg_half_t state_q;
    logic     tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (start) begin
                state_q.count <= bg_reload(tc);
                state_q.level <= 1'b0;
            end else if (step) begin
                if (state_q.count == '0) begin
                    state_q.count <= bg_reload(tc);
                    state_q.level <= ~state_q.level;
                    tick_q        <= state_q.level;
                end else begin
                    state_q.count <= state_q.count - 1'b1;
                end
            end
        end
    end

    assign level     = state_q.level;
    assign full_tick = tick_q;

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (!step && !start) |=> ($stable(state_q.count) && $stable(state_q.level)));

    assert_tick_after_fall_R4: assert property (@(posedge clk) disable iff (rst)
        full_tick |-> ($past(state_q.level) && !state_q.level));

endmodule

// File: rtl/baud_gen_os.sv
module baud_gen_os #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick_in,
    output logic tick_out
);

    localparam int SUB_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [SUB_W-1:0] LAST = SUB_W'(OVERSAMPLE - 1);

    logic [SUB_W-1:0] sub_q;

    generate
        if (OVERSAMPLE == (1 << SUB_W)) begin : g_pow2
            always_ff @(posedge clk) begin
                if (rst || start) sub_q <= '0;
                else if (tick_in) sub_q <= sub_q + 1'b1;
            end
        end else begin : g_any
            always_ff @(posedge clk) begin
                if (rst || start) sub_q <= '0;
                else if (tick_in) sub_q <= (sub_q == LAST) ? '0 : sub_q + 1'b1;
            end
        end
    endgenerate

    assign tick_out = tick_in && (sub_q == LAST);

    assert_sub_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (!tick_in && !start) |=> $stable(sub_q));

endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_gen_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BG_BYTE_W-1:0] tc_lo,
    input  logic [BG_BYTE_W-1:0] tc_hi,
    input  logic                 gen_en,
    input  logic                 src_main,
    input  logic                 alt_ce,
    output logic                 baud_clk,
    output logic                 baud_tick,
    output logic                 bit_tick
);

    logic               en_q;
    logic               start;
    logic               step;
    logic [BG_TC_W-1:0] tc;
    bg_src_e            src;

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= gen_en;
    end

    assign start = gen_en && !en_q;
    assign tc    = {tc_hi, tc_lo};
    assign src   = src_main ? SRC_MAIN : SRC_ALT;

    baud_gen_step u_step (
        .gen_en (gen_en),
        .start  (start),
        .src    (src),
        .alt_ce (alt_ce),
        .step   (step)
    );

    baud_gen_half u_half (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .step      (step),
        .tc        (tc),
        .level     (baud_clk),
        .full_tick (baud_tick)
    );

    baud_gen_os #(.OVERSAMPLE(OVERSAMPLE)) u_os (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .tick_in  (baud_tick),
        .tick_out (bit_tick)
    );

    assert_tick_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> $past(gen_en));

    assert_bit_on_baud_R5: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> baud_tick);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        baud_tick |=> !baud_tick);

    assert_level_frozen_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!gen_en && !$past(gen_en)) |-> $stable(baud_clk));

endmodule

// File: tb/sim_baud_gen.sv
module sim_baud_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] tc_lo = 8'd0;
    logic [7:0] tc_hi = 8'd0;
    logic       gen_en = 1'b0;
    logic       src_main = 1'b1;
    logic       alt_ce = 1'b0;
    logic       baud_clk, baud_tick, bit_tick;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    int adiv = 0;
    int acnt = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // alternate strobe: high one cycle in every adiv cycles, low when adiv==0
    always @(negedge clk) begin
        if (adiv == 0) begin
            alt_ce = 1'b0;
            acnt = 0;
        end else begin
            alt_ce = (acnt == 0);
            acnt = (acnt >= adiv - 1) ? 0 : acnt + 1;
        end
    end

    baud_gen u0 (
        .clk(clk), .rst(rst), .tc_lo(tc_lo), .tc_hi(tc_hi),
        .gen_en(gen_en), .src_main(src_main), .alt_ce(alt_ce),
        .baud_clk(baud_clk), .baud_tick(baud_tick), .bit_tick(bit_tick)
    );

    typedef struct packed {
        logic [15:0] tc;
        logic        main;
        logic [3:0]  div;
        logic [31:0] per;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'd0,   1'b1, 4'd0, 32'd4},    // R2
        '{16'd1,   1'b1, 4'd3, 32'd6},    // R1 R11
        '{16'd2,   1'b1, 4'd0, 32'd8},    // R3
        '{16'd7,   1'b1, 4'd2, 32'd18},   // R1 R11
        '{16'd300, 1'b1, 4'd0, 32'd604},  // R1 (high byte used)
        '{16'd2,   1'b0, 4'd3, 32'd24},   // R8
        '{16'd5,   1'b0, 4'd2, 32'd28},   // R8
        '{16'd0,   1'b0, 4'd1, 32'd4}     // R8
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic next_tick(output int t);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!baud_tick && guard < 20000);
        t = baud_tick ? cyc : -1;
    endtask

    task automatic next_bit(output int t);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!bit_tick && guard < 40000);
        t = bit_tick ? cyc : -1;
    endtask

    task automatic restart(input logic [15:0] tc, input logic main, input int div);
        @(negedge clk);
        gen_en = 1'b0;
        {tc_hi, tc_lo} = tc;
        src_main = main;
        adiv = div;
        repeat (3) @(negedge clk);
        gen_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int t0, t1, t2, c0, cnt;
        logic lvl;
        repeat (4) @(negedge clk);
        // R10 reset state
        check(!baud_tick && !bit_tick && !baud_clk, "R10", {baud_tick, bit_tick, baud_clk}, 0);
        @(negedge clk);
        rst = 1'b0;

        // vector table: steady period
        for (int i = 0; i < NV; i++) begin
            restart(VECS[i].tc, VECS[i].main, int'(VECS[i].div));
            next_tick(t0);
            next_tick(t1);
            next_tick(t2);
            check((t2 - t1) == int'(VECS[i].per) && (t1 - t0) == int'(VECS[i].per),
                  VECS[i].main ? "R1" : "R8", t2 - t1, int'(VECS[i].per));
        end

        // R6 first-tick latency after enable, T=3
        restart(16'd3, 1'b1, 0);
        c0 = cyc;
        next_tick(t0);
        check((t0 - c0) == 11, "R6", t0 - c0, 11);
        restart(16'd1, 1'b1, 0);
        c0 = cyc;
        next_bit(t0);
        check((t0 - c0) == 97, "R6", t0 - c0, 97);

        // R5 bit_tick period and coincidence; R3 bit period at T=2
        next_bit(t1);
        check((t1 - t0) == 96, "R5", t1 - t0, 96);
        restart(16'd2, 1'b1, 0);
        next_bit(t0);
        next_bit(t1);
        check((t1 - t0) == 128, "R3", t1 - t0, 128);

        // R4 pulse width
        restart(16'd0, 1'b1, 0);
        next_tick(t0);
        @(negedge clk);
        check(!baud_tick, "R4", baud_tick, 0);

        // R9 mid-count change: old half of 12, new half of 2, then 4
        restart(16'd10, 1'b1, 0);
        next_tick(t0);
        next_tick(t0);
        {tc_hi, tc_lo} = 16'd0;
        next_tick(t1);
        check((t1 - t0) == 14, "R9", t1 - t0, 14);
        next_tick(t2);
        check((t2 - t1) == 4, "R9", t2 - t1, 4);

        // R7 disabled: no ticks, level held
        @(negedge clk);
        gen_en = 1'b0;
        @(negedge clk);
        lvl = baud_clk;
        cnt = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (baud_tick || bit_tick || baud_clk != lvl) cnt++;
        end
        check(cnt == 0, "R7", cnt, 0);

        // R8 alternate source with strobe held low
        restart(16'd0, 1'b0, 0);
        cnt = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (baud_tick) cnt++;
        end
        check(cnt == 0, "R8", cnt, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule